// File: doc/BRIEF.md
# Voice Group Playback Sequencer

This block plays back one voice group at a time. A group is an ordered run of entries in a shared combination table, and each entry names one fixed-length voice block held in a synchronous sample ROM. The same block may be named by many entries, so long phrases are built out of short reusable pieces. Each group has its own first and last table index, given on configuration inputs. When a group starts, the sequencer reads its first table entry to get a block index. It then reads that block's bytes from the ROM, one per sample tick. When the byte counter wraps, it moves to the next entry, and it stops after the last entry.

A global option selects the sample format. In PCM mode each byte is one 8-bit sample. In ADPCM mode each byte carries two 4-bit codes for a downstream decoder, which doubles the samples per block. Every group also carries three trigger options: edge or level start, holdable or unholdable, and retriggerable or not. These options decide how a request from the trigger logic starts, sustains, restarts or ends playback. A stop input ends playback at once.

Both memories are synchronous and have one cycle of read latency. Sample ticks must be at least four clock cycles apart. Each group's first index must not be greater than its last index.

Top module: `voice_group_seq`

## Requirements
- R1: On a start, the table is read from the group's first index up to its last index in ascending order. Each table word is used as the block index, and the ROM address is {block index, byte offset}.
- R2: Inside a block, byte offsets run from 0 to BLOCK_BYTES-1. The ROM address changes only after a sample tick, and the wrap of the byte offset moves playback to the next table entry.
- R3: With pcm_i=1, every sample tick during playback produces one sample equal to the ROM byte. The sample appears with sample_vld_o exactly two cycles after that tick.
- R4: With pcm_i=0, each byte yields two samples on two successive ticks: bits [7:4] first, then bits [3:0]. Each code is placed in sample_o[3:0] with sample_o[7:4]=0.
- R5: A group whose option bit is 1 in opt_edge_i starts only on a 0-to-1 change of trig_i. A level group starts whenever trig_i is 1 while the sequencer is inactive, so a level unholdable group held on plays its whole list again and again.
- R6: For a holdable group (opt_hold_i bit 1), a sample tick that sees trig_i=0 ends playback with no further sample. An unholdable group plays to the end of its list after trig_i is released.
- R7: For a playing group with its opt_retrig_i bit set, a 0-to-1 change of trig_i restarts playback at the first entry of the group on grp_i. A sample still in flight is dropped. A non-retriggerable group ignores new triggers while it plays.
- R8: stop_i=1 makes the block inactive on the next cycle. busy_o is then 0 and no further sample appears.
- R9: busy_o is 1 from the cycle after a start until the cycle that presents the last sample. eog_o pulses once, together with sample_vld_o, on the final sample of a group that plays to its end.
- R10: A group number of NUM_GROUPS or more on grp_i is ignored.
- R11: After reset, busy_o, sample_vld_o and eog_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_i | input | 1 | Ends playback at once |
| tick_i | input | 1 | Sample-rate strobe, one cycle wide |
| pcm_i | input | 1 | 1 = 8-bit PCM, 0 = 4-bit codes |
| trig_i | input | 1 | Trigger level from the trigger logic |
| grp_i | input | GW | Requested group number |
| opt_edge_i | input | NUM_GROUPS | Per group: 1 = edge start, 0 = level start |
| opt_hold_i | input | NUM_GROUPS | Per group: 1 = holdable |
| opt_retrig_i | input | NUM_GROUPS | Per group: 1 = retriggerable |
| grp_first_i | input | NUM_GROUPS*TW | Per-group first table index, group g at [g*TW +: TW] |
| grp_last_i | input | NUM_GROUPS*TW | Per-group last table index, same packing |
| tbl_addr_o | output | TW | Combination table read address |
| tbl_data_i | input | BW | Block index read from the table |
| rom_addr_o | output | BW+YW | Sample ROM read address |
| rom_data_i | input | 8 | Sample ROM read data |
| sample_o | output | 8 | Sample or zero-extended 4-bit code |
| sample_vld_o | output | 1 | sample_o is valid this cycle |
| eog_o | output | 1 | Final sample of the group |
| busy_o | output | 1 | Playback in progress |

## Verification
The assertions watch properties that must hold on every cycle, whatever the stimulus:
- a sample always follows a tick by exactly two cycles;
- 4-bit codes always have a zero upper half;
- the ROM address stays still between ticks;
- the table address never passes the active group's last index;
- eog_o only appears together with a sample;
- stop_i always makes the block inactive on the next cycle.

Only the bench scenarios can show the rest, because each needs a reference sequence or a trigger history:
- that the right entries and bytes come out in the right order;
- that level groups repeat while edge groups do not;
- that releasing a holdable group cuts playback short;
- that a retrigger switches to a new group's full sequence;
- that out-of-range group numbers are ignored.

// File: rtl/vgs_pkg.sv
package vgs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOK,
    ST_LOAD,
    ST_PLAY
  } seq_st_e;
endpackage

// File: rtl/vgs_trig.sv
// Qualifies trigger requests against the per-group start, hold and retrigger options.
module vgs_trig #(
  parameter int NG = 12,
  parameter int GW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_i,
  input  logic [GW-1:0] grp_i,
  input  logic [NG-1:0] opt_edge_i,
  input  logic [NG-1:0] opt_hold_i,
  input  logic [NG-1:0] opt_retrig_i,
  input  logic [GW-1:0] cur_g_i,
  input  logic          active_i,
  output logic          start_o,
  output logic          restart_o,
  output logic          release_o
);
  logic trig_q;
  logic rise;
  logic grp_ok;
  logic req_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= trig_i;
  end

  always_comb begin
    rise      = trig_i & ~trig_q;
    grp_ok    = ({1'b0, grp_i} < (GW+1)'(NG));
    req_edge  = grp_ok & opt_edge_i[grp_i];
    start_o   = ~active_i & grp_ok & (req_edge ? rise : trig_i);
    restart_o = active_i & grp_ok & rise & opt_retrig_i[cur_g_i];
    release_o = active_i & opt_hold_i[cur_g_i] & ~trig_i;
  end
endmodule

// File: rtl/vgs_cursor.sv
// Byte offset and nibble phase within the current voice block.
module vgs_cursor #(
  parameter int BB = 256,
  parameter int YW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          step_i,
  input  logic          pcm_i,
  output logic [YW-1:0] byte_o,
  output logic          nib_o,
  output logic          wrap_o
);
  localparam logic [YW-1:0] LAST_BYTE = YW'(BB - 1);

  logic [YW-1:0] byte_q, byte_d;
  logic          nib_q, nib_d;
  logic          adv_byte;

  always_comb begin
    adv_byte = pcm_i | nib_q;
    wrap_o   = adv_byte & (byte_q == LAST_BYTE);
    byte_d   = byte_q;
    nib_d    = nib_q;
    if (clr_i) begin
      byte_d = '0;
      nib_d  = 1'b0;
    end else if (step_i) begin
      if (adv_byte) begin
        nib_d  = 1'b0;
        byte_d = wrap_o ? '0 : byte_q + YW'(1);
      end else begin
        nib_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      nib_q  <= 1'b0;
    end else begin
      byte_q <= byte_d;
      nib_q  <= nib_d;
    end
  end

  assign byte_o = byte_q;
  assign nib_o  = nib_q;
endmodule

// File: rtl/vgs_out.sv
// Aligns ROM read data with its fetch and formats the output sample.
module vgs_out (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush_i,
  input  logic       fetch_i,
  input  logic       nib_i,
  input  logic       last_i,
  input  logic       pcm_i,
  input  logic [7:0] rom_data_i,
  output logic       pend_o,
  output logic [7:0] sample_o,
  output logic       vld_o,
  output logic       eog_o
);
  logic       pend_q, pend_d;
  logic       pnib_q, plast_q;
  logic [7:0] smp_q, smp_d;
  logic       vld_q, vld_d;
  logic       eog_q, eog_d;
  logic       cap_en;

  always_comb begin
    pend_d = fetch_i & ~flush_i;
    vld_d  = pend_q & ~flush_i;
    eog_d  = pend_q & plast_q & ~flush_i;
    cap_en = pend_q;
    if (pcm_i)       smp_d = rom_data_i;
    else if (pnib_q) smp_d = {4'h0, rom_data_i[3:0]};
    else             smp_d = {4'h0, rom_data_i[7:4]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      pnib_q  <= 1'b0;
      plast_q <= 1'b0;
      smp_q   <= '0;
      vld_q   <= 1'b0;
      eog_q   <= 1'b0;
    end else begin
      pend_q <= pend_d;
      vld_q  <= vld_d;
      eog_q  <= eog_d;
      if (fetch_i) begin
        pnib_q  <= nib_i;
        plast_q <= last_i;
      end
      if (cap_en) smp_q <= smp_d;
    end
  end

  assign pend_o   = pend_q;
  assign sample_o = smp_q;
  assign vld_o    = vld_q;
  assign eog_o    = eog_q;
endmodule

// File: rtl/voice_group_seq.sv
module voice_group_seq
  import vgs_pkg::*;
#(
  parameter int NUM_GROUPS  = 12,
  parameter int TABLE_DEPTH = 960,
  parameter int NUM_BLOCKS  = 126,
  parameter int BLOCK_BYTES = 256,
  localparam int GW = $clog2(NUM_GROUPS),
  localparam int TW = $clog2(TABLE_DEPTH),
  localparam int BW = $clog2(NUM_BLOCKS),
  localparam int YW = $clog2(BLOCK_BYTES),
  localparam int RW = BW + YW
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     stop_i,
  input  logic                     tick_i,
  input  logic                     pcm_i,
  input  logic                     trig_i,
  input  logic [GW-1:0]            grp_i,
  input  logic [NUM_GROUPS-1:0]    opt_edge_i,
  input  logic [NUM_GROUPS-1:0]    opt_hold_i,
  input  logic [NUM_GROUPS-1:0]    opt_retrig_i,
  input  logic [NUM_GROUPS*TW-1:0] grp_first_i,
  input  logic [NUM_GROUPS*TW-1:0] grp_last_i,
  output logic [TW-1:0]            tbl_addr_o,
  input  logic [BW-1:0]            tbl_data_i,
  output logic [RW-1:0]            rom_addr_o,
  input  logic [7:0]               rom_data_i,
  output logic [7:0]               sample_o,
  output logic                     sample_vld_o,
  output logic                     eog_o,
  output logic                     busy_o
);
  logic [TW-1:0] first_a [NUM_GROUPS];
  logic [TW-1:0] last_a  [NUM_GROUPS];

  for (genvar gi = 0; gi < NUM_GROUPS; gi++) begin : g_cfg
    assign first_a[gi] = grp_first_i[gi*TW +: TW];
    assign last_a[gi]  = grp_last_i[gi*TW +: TW];
  end

  seq_st_e       state_q, state_d;
  logic [TW-1:0] entry_q, entry_d;
  logic [TW-1:0] last_q, last_d;
  logic [GW-1:0] cur_g_q, cur_g_d;
  logic [BW-1:0] blk_q, blk_d;

  logic          active, go, fetch, at_last;
  logic          start, restart, release_req;
  logic [YW-1:0] byte_w;
  logic          nib_w, wrap_w, pend_w;

  assign active  = (state_q != ST_IDLE);
  assign go      = start | restart;
  assign at_last = (entry_q == last_q);
  assign fetch   = (state_q == ST_PLAY) & tick_i & ~release_req & ~restart & ~stop_i;

  vgs_trig #(.NG(NUM_GROUPS), .GW(GW)) u_trig (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig_i      (trig_i),
    .grp_i       (grp_i),
    .opt_edge_i  (opt_edge_i),
    .opt_hold_i  (opt_hold_i),
    .opt_retrig_i(opt_retrig_i),
    .cur_g_i     (cur_g_q),
    .active_i    (active),
    .start_o     (start),
    .restart_o   (restart),
    .release_o   (release_req)
  );

  vgs_cursor #(.BB(BLOCK_BYTES), .YW(YW)) u_cursor (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (go | stop_i),
    .step_i(fetch),
    .pcm_i (pcm_i),
    .byte_o(byte_w),
    .nib_o (nib_w),
    .wrap_o(wrap_w)
  );

  vgs_out u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush_i   (stop_i | restart),
    .fetch_i   (fetch),
    .nib_i     (nib_w),
    .last_i    (wrap_w & at_last),
    .pcm_i     (pcm_i),
    .rom_data_i(rom_data_i),
    .pend_o    (pend_w),
    .sample_o  (sample_o),
    .vld_o     (sample_vld_o),
    .eog_o     (eog_o)
  );

  always_comb begin
    state_d = state_q;
    entry_d = entry_q;
    last_d  = last_q;
    cur_g_d = cur_g_q;
    blk_d   = blk_q;
    if (stop_i) begin
      state_d = ST_IDLE;
    end else if (go) begin
      state_d = ST_LOOK;
      cur_g_d = grp_i;
      entry_d = first_a[grp_i];
      last_d  = last_a[grp_i];
    end else begin
      unique case (state_q)
        ST_LOOK: state_d = ST_LOAD;
        ST_LOAD: begin
          blk_d   = tbl_data_i;
          state_d = ST_PLAY;
        end
        ST_PLAY: begin
          if (tick_i & release_req) begin
            state_d = ST_IDLE;
          end else if (fetch & wrap_w) begin
            if (at_last) begin
              state_d = ST_IDLE;
            end else begin
              entry_d = entry_q + TW'(1);
              state_d = ST_LOOK;
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      entry_q <= '0;
      last_q  <= '0;
      cur_g_q <= '0;
      blk_q   <= '0;
    end else begin
      state_q <= state_d;
      entry_q <= entry_d;
      last_q  <= last_d;
      cur_g_q <= cur_g_d;
      blk_q   <= blk_d;
    end
  end

  assign tbl_addr_o = entry_q;
  assign rom_addr_o = {blk_q, byte_w};
  assign busy_o     = active | pend_w | sample_vld_o;
endmodule

// File: rtl/vgs_chk.sv
module vgs_chk
  import vgs_pkg::*;
#(
  parameter int TW = 10,
  parameter int RW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stop_i,
  input logic          tick_i,
  input logic          pcm_i,
  input logic          busy_o,
  input logic          sample_vld_o,
  input logic          eog_o,
  input logic [7:0]    sample_o,
  input logic [TW-1:0] tbl_addr_o,
  input logic [RW-1:0] rom_addr_o,
  input seq_st_e       state_i,
  input logic [TW-1:0] last_i
);
  AST_TABLE_IN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i != ST_IDLE) |-> (tbl_addr_o <= last_i)); // R1

  AST_ROM_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_i == ST_PLAY && !tick_i && !stop_i) && state_i == ST_PLAY)
      |-> $stable(rom_addr_o)); // R2

  AST_SAMPLE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld_o |-> $past(tick_i, 2)); // R3

  AST_CODE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld_o && !pcm_i) |-> (sample_o[7:4] == 4'h0)); // R4

  AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !busy_o); // R8

  AST_EOG_WITH_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    eog_o |-> (sample_vld_o && busy_o)); // R9
endmodule

bind voice_group_seq vgs_chk #(.TW(TW), .RW(RW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .stop_i      (stop_i),
  .tick_i      (tick_i),
  .pcm_i       (pcm_i),
  .busy_o      (busy_o),
  .sample_vld_o(sample_vld_o),
  .eog_o       (eog_o),
  .sample_o    (sample_o),
  .tbl_addr_o  (tbl_addr_o),
  .rom_addr_o  (rom_addr_o),
  .state_i     (state_q),
  .last_i      (last_q)
);

// File: tb/tb_voice_group_seq.sv
module tb_voice_group_seq;
  localparam int NG = 12;
  localparam int TW = 10;
  localparam int GW = 4;
  localparam int BW = 7;
  localparam int BB = 4;
  localparam int RW = 9;

  logic clk = 1'b0;
  logic rst_n, stop_i, tick_i, pcm_i, trig_i;
  logic [GW-1:0] grp_i;
  logic [NG-1:0] opt_edge, opt_hold, opt_retrig;
  logic [NG*TW-1:0] gfirst, glast;
  logic [TW-1:0] tbl_addr;
  logic [BW-1:0] tbl_data;
  logic [RW-1:0] rom_addr;
  logic [7:0] rom_data, sample;
  logic sample_vld, eog, busy;

  int checks = 0, fails = 0;
  int cap [1024];
  int ncap, neog, eog_at;
  int exp_s [1024];
  int exp_n;
  int tdiv = 0;
  logic tick_en;
  logic done_flag = 1'b0;

  always #4 clk = ~clk;

  voice_group_seq #(.BLOCK_BYTES(BB)) dut (
    .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .tick_i(tick_i), .pcm_i(pcm_i),
    .trig_i(trig_i), .grp_i(grp_i), .opt_edge_i(opt_edge), .opt_hold_i(opt_hold),
    .opt_retrig_i(opt_retrig), .grp_first_i(gfirst), .grp_last_i(glast),
    .tbl_addr_o(tbl_addr), .tbl_data_i(tbl_data), .rom_addr_o(rom_addr),
    .rom_data_i(rom_data), .sample_o(sample), .sample_vld_o(sample_vld),
    .eog_o(eog), .busy_o(busy)
  );

  function automatic int tbl_f(int e);
    return (e * 7 + 3) % 126;
  endfunction

  function automatic int rom_f(int a);
    return (a * 37 + 11) % 256;
  endfunction

  function automatic int g_first(int g);
    return (g == 11) ? 950 : g * 40;
  endfunction

  function automatic int g_last(int g);
    return (g == 11) ? 959 : g * 40 + g % 3;
  endfunction

  always @(posedge clk) begin
    tbl_data <= BW'(tbl_f(int'(tbl_addr)));
    rom_data <= 8'(rom_f(int'(rom_addr)));
  end

  always @(negedge clk) begin
    tick_i <= tick_en && (tdiv == 0);
    tdiv   <= (tdiv == 5) ? 0 : tdiv + 1;
    if (sample_vld && ncap < 1024) begin
      cap[ncap] = int'(sample);
      ncap = ncap + 1;
      if (eog) begin
        neog   = neog + 1;
        eog_at = ncap;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic build(input int g, input bit pcm);
    exp_n = 0;
    for (int e = g_first(g); e <= g_last(g); e++) begin
      for (int b = 0; b < BB; b++) begin
        int by;
        by = rom_f(tbl_f(e) * BB + b);
        if (pcm) begin
          exp_s[exp_n] = by; exp_n++;
        end else begin
          exp_s[exp_n] = by / 16; exp_n++;
          exp_s[exp_n] = by % 16; exp_n++;
        end
      end
    end
  endtask

  task automatic clr_cap();
    ncap = 0; neog = 0; eog_at = -1;
  endtask

  task automatic fire(input int g, input int cyc);
    @(negedge clk);
    grp_i  = GW'(g);
    trig_i = 1'b1;
    repeat (cyc) @(negedge clk);
    trig_i = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int k;
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (busy && k < 20000);
    chk(!busy, req, int'(busy), 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_cap(input int n);
    for (int k = 0; k < 20000 && ncap < n; k++) @(negedge clk);
  endtask

  task automatic match_from(input int off, input int n, input int eoff, input string req);
    int bad;
    bad = -1;
    for (int i = 0; i < n; i++) if (bad < 0 && cap[off + i] != exp_s[eoff + i]) bad = i;
    if (bad < 0) chk(1'b1, req, 0, 0);
    else chk(1'b0, req, cap[off + bad], exp_s[eoff + bad]);
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R11 busy", int'(busy), 0);
    chk(sample_vld == 1'b0, "R11 vld", int'(sample_vld), 0);
    chk(eog == 1'b0, "R11 eog", int'(eog), 0);
  endtask

  task automatic t_pcm_group();
    pcm_i = 1'b1; opt_edge = '1; opt_hold = '0; opt_retrig = '0;
    build(4, 1'b1); clr_cap();
    fire(4, 2);
    wait_idle("R9 pcm end");
    chk(ncap == exp_n, "R3 pcm count", ncap, exp_n);
    match_from(0, exp_n, 0, "R1 R2 R3 pcm order");
    chk(neog == 1, "R9 eog count", neog, 1);
    chk(eog_at == exp_n, "R9 eog on last", eog_at, exp_n);
  endtask

  task automatic t_adpcm_group();
    pcm_i = 1'b0; opt_edge = '1; opt_hold = '0; opt_retrig = '0;
    build(11, 1'b0); clr_cap();
    fire(11, 2);
    wait_idle("R4 adpcm end");
    chk(ncap == exp_n, "R4 code count", ncap, exp_n);
    match_from(0, exp_n, 0, "R4 high nibble first");
    chk(eog_at == exp_n, "R9 adpcm eog", eog_at, exp_n);
  endtask

  task automatic t_level_repeat();
    int L;
    pcm_i = 1'b1; opt_edge = '0; opt_hold = '0; opt_retrig = '0;
    build(2, 1'b1); L = exp_n; clr_cap();
    @(negedge clk); grp_i = 4'd2; trig_i = 1'b1;
    wait_cap(L + 2);
    trig_i = 1'b0;
    wait_idle("R5 level end");
    chk(ncap >= 2 * L && ncap % L == 0, "R5 level repeats whole list", ncap, 2 * L);
    for (int i = 0; i < ncap; i++) exp_s[i] = exp_s[i % L];
    match_from(0, ncap, 0, "R5 repeated content");
    chk(neog == ncap / L, "R5 eog per pass", neog, ncap / L);
  endtask

  task automatic t_edge_held();
    pcm_i = 1'b1; opt_edge = '1; opt_hold = '0; opt_retrig = '0;
    build(2, 1'b1); clr_cap();
    @(negedge clk); grp_i = 4'd2; trig_i = 1'b1;
    repeat (3) @(negedge clk);
    wait_idle("R5 edge end");
    repeat (40) @(negedge clk);
    chk(!busy, "R5 edge no restart while held", int'(busy), 0);
    trig_i = 1'b0;
    chk(ncap == exp_n, "R5 edge single pass", ncap, exp_n);
  endtask

  task automatic t_hold_release();
    pcm_i = 1'b1; opt_edge = '0; opt_hold = '0; opt_retrig = '0;
    opt_hold[11] = 1'b1;
    build(11, 1'b1); clr_cap();
    @(negedge clk); grp_i = 4'd11; trig_i = 1'b1;
    wait_cap(5);
    trig_i = 1'b0;
    wait_idle("R6 hold release ends");
    chk(ncap >= 5 && ncap < exp_n, "R6 cut short", ncap, 5);
    match_from(0, ncap, 0, "R6 prefix content");
    chk(neog == 0, "R6 no eog on release", neog, 0);
  endtask

  task automatic t_retrig();
    int LB, k;
    pcm_i = 1'b1; opt_edge = '1; opt_hold = '0; opt_retrig = '0;
    opt_retrig[11] = 1'b1;
    clr_cap();
    fire(11, 2);
    wait_cap(3);
    fire(1, 2);
    wait_idle("R7 retrig end");
    build(1, 1'b1); LB = exp_n;
    k = ncap - LB;
    chk(k >= 3, "R7 samples before restart", k, 3);
    match_from(k, LB, 0, "R7 new group full list");
    build(11, 1'b1);
    match_from(0, (k < 3) ? 0 : 3, 0, "R7 first group prefix");
    chk(neog == 1, "R7 single eog", neog, 1);
  endtask

  task automatic t_nonretrig();
    pcm_i = 1'b1; opt_edge = '1; opt_hold = '0; opt_retrig = '0;
    build(11, 1'b1); clr_cap();
    fire(11, 2);
    wait_cap(3);
    fire(1, 2);
    wait_idle("R7 nonretrig end");
    chk(ncap == exp_n, "R7 trigger ignored count", ncap, exp_n);
    match_from(0, exp_n, 0, "R7 trigger ignored content");
  endtask

  task automatic t_stop();
    int n;
    pcm_i = 1'b1; opt_edge = '1; opt_hold = '0; opt_retrig = '0;
    clr_cap();
    fire(11, 2);
    wait_cap(4);
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    chk(!busy, "R8 inactive after stop", int'(busy), 0);
    n = ncap;
    repeat (60) @(negedge clk);
    chk(ncap == n, "R8 no samples after stop", ncap, n);
  endtask

  task automatic t_bad_group();
    int hit;
    pcm_i = 1'b1; opt_edge = '0; opt_hold = '0; opt_retrig = '0;
    clr_cap(); hit = 0;
    @(negedge clk); grp_i = 4'd13; trig_i = 1'b1;
    repeat (30) begin
      @(negedge clk);
      if (busy) hit++;
    end
    trig_i = 1'b0;
    chk(hit == 0, "R10 out-of-range group ignored", hit, 0);
    chk(ncap == 0, "R10 no samples", ncap, 0);
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    end
  endtask

  initial begin
    rst_n = 1'b0; stop_i = 1'b0; tick_en = 1'b0; pcm_i = 1'b1; trig_i = 1'b0;
    grp_i = '0; opt_edge = '0; opt_hold = '0; opt_retrig = '0;
    for (int g = 0; g < NG; g++) begin
      gfirst[g*TW +: TW] = TW'(g_first(g));
      glast[g*TW +: TW]  = TW'(g_last(g));
    end
    clr_cap();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    tick_en = 1'b1;
    t_pcm_group();
    t_adpcm_group();
    t_level_repeat();
    t_edge_held();
    t_hold_release();
    t_retrig();
    t_nonretrig();
    t_stop();
    t_bad_group();
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end
endmodule